// File: doc/BRIEF.md
# Open-Row-First DRAM Bank Scheduler

This block sits in a memory controller between a request source and the DRAM command bus. It keeps a small queue of pending accesses in arrival order. Each access names a bank, a row, a column, a direction and a tag. Every bank has one row buffer, and the block tracks which row, if any, each buffer holds. In every cycle the block chooses at most one queued access. It then issues the next command that access needs: an activate to open its row, a precharge to close a different row, or the column read or write. The per-bank row timing is enforced throughout.

A mode input selects one of two policies. In strict in-order mode only the oldest queued access may advance. In open-row-first mode the whole queue is searched each cycle. An access whose row is already open and whose column command is legal goes first, and among several such accesses the oldest wins. When no such access exists, the oldest access that can legally move its bank forward is chosen. Because the banks are independent, commands to different banks interleave freely. An access leaves the queue in the cycle its column command issues, and a one-cycle completion pulse returns its tag at that point.

Top module: `dram_frfcfs_sched`

## Requirements
- R1: After reset no command is issued, `cmd_kind` is 0, no completion is signalled, `req_ready` is 1 and every bank is treated as closed.
- R2: A request offered with `req_valid` is taken at the clock edge when the queue holds fewer than QDEPTH entries. `req_ready` is 0 while the queue is full, and a request offered then is dropped and never served.
- R3: Command codes on `cmd_kind` are 0 for none, 1 for activate, 2 for precharge, 3 for read and 4 for write. An access to a closed bank gets an activate, which carries its bank and row. An access to an open bank holding another row gets a precharge, which carries only its bank, with row and column driven as 0. An access whose row is open gets a read or write, which carries its bank, row and column.
- R4: A read or write to a bank is issued no sooner than TRCD cycles after that bank's last activate.
- R5: An activate to a bank is issued no sooner than TRP cycles after that bank's last precharge.
- R6: Two activates to the same bank are at least TRC cycles apart.
- R7: With `fifo_mode` high, only the oldest queued access may receive a command. When its next command is not yet legal, nothing is issued.
- R8: With `fifo_mode` low, a queued access whose row is open and whose column command is legal is always served before any other, the oldest such access first.
- R9: With `fifo_mode` low and no such access, the oldest access whose next command is legal is chosen. An access that does not hit its bank's open row is skipped while an older access to the same bank is queued, or while any queued access hits that bank's open row.
- R10: At most one command issues per cycle, one cycle after the deciding edge. `done_valid` pulses with the access's tag in exactly the cycle of its read or write, and that access leaves the queue. When idle, every command field and `done_tag` read 0.
- R11: Banks are independent: a timing wait on one bank does not hold back commands to other banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 selects strict in-order service, 0 open-row-first |
| req_valid | input | 1 | A request is offered this cycle |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 for write, 0 for read |
| req_tag | input | TAG_W | Identifier returned on completion |
| req_ready | output | 1 | Queue has a free entry |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_kind | output | 3 | Command code (see R3) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for activate, read and write |
| cmd_col | output | COL_W | Column for read and write |
| done_valid | output | 1 | An access completed this cycle |
| done_tag | output | TAG_W | Tag of the completed access |

## Verification
The bound checker watches the command bus on every cycle. It tracks each bank's open row from the commands themselves and checks the activate, precharge and column spacings against TRCD, TRP and TRC. It also checks that every command fits the tracked bank state and that completions coincide with column commands. Which access gets chosen cannot be seen on the bus alone. The ordering under both policies, the skipping rules for non-hitting accesses, the dropping of requests while the queue is full and the tag returned with each completion are all shown by the bench. Its reference model predicts every bus value cycle by cycle and compares against the design.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
   typedef enum logic [2:0] {
      CMD_NONE = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_PRE  = 3'd2,
      CMD_RD   = 3'd3,
      CMD_WR   = 3'd4
   } dram_cmd_e;
endpackage

// File: rtl/dram_bank_timer.sv
// One bank: open-row tracking plus the three spacing counters.
module dram_bank_timer #(
   parameter int ROW_W = 8,
   parameter int TRCD  = 3,
   parameter int TRP   = 2,
   parameter int TRC   = 7,
   localparam int CW   = $clog2(TRC + TRCD + TRP + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             pre_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             col_ok_o,
   output logic             act_ok_o
);
   logic [CW-1:0] rcd_q, rp_q, rc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
         rcd_q  <= '0;
         rp_q   <= '0;
         rc_q   <= '0;
      end else begin
         rcd_q <= act_i ? CW'(TRCD - 1) : (rcd_q != '0 ? rcd_q - CW'(1) : '0);
         rc_q  <= act_i ? CW'(TRC - 1)  : (rc_q  != '0 ? rc_q  - CW'(1) : '0);
         rp_q  <= pre_i ? CW'(TRP - 1)  : (rp_q  != '0 ? rp_q  - CW'(1) : '0);
         if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
         end else if (pre_i) begin
            open_o <= 1'b0;
         end
      end
   end

   assign col_ok_o = (rcd_q == '0);
   assign act_ok_o = (rp_q == '0) && (rc_q == '0);
endmodule

// File: rtl/dram_req_queue.sv
// Age-ordered queue: slot 0 is oldest, removal anywhere closes the gap.
module dram_req_queue #(
   parameter int DEPTH = 4,
   parameter int ENT_W = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push_i,
   input  logic [ENT_W-1:0]            push_data_i,
   input  logic                        pop_i,
   input  logic [IDX_W-1:0]            pop_idx_i,
   output logic [DEPTH-1:0][ENT_W-1:0] ent_o,
   output logic [DEPTH-1:0]            valid_o,
   output logic                        full_o
);
   logic [DEPTH-1:0][ENT_W-1:0] mem_q, mem_d;
   logic [CNT_W-1:0]            cnt_q, cnt_mid;

   always_comb begin
      cnt_mid = cnt_q - CNT_W'(pop_i);
      for (int i = 0; i < DEPTH - 1; i++)
         mem_d[i] = (pop_i && IDX_W'(i) >= pop_idx_i) ? mem_q[i+1] : mem_q[i];
      mem_d[DEPTH-1] = mem_q[DEPTH-1];
      for (int i = 0; i < DEPTH; i++)
         if (push_i && cnt_mid == CNT_W'(i)) mem_d[i] = push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
         cnt_q <= '0;
      end else begin
         mem_q <= mem_d;
         cnt_q <= cnt_mid + CNT_W'(push_i);
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_valid
      assign valid_o[g] = (cnt_q > CNT_W'(g));
   end
   assign ent_o  = mem_q;
   assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/dram_req_pick.sv
// Chooses one queued access and the command it needs this cycle.
module dram_req_pick import dram_sched_pkg::*; #(
   parameter int DEPTH = 4,
   parameter int BANKS = 4,
   parameter int ROW_W = 8,
   localparam int BANK_W = $clog2(BANKS),
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0][BANK_W-1:0] bank_i,
   input  logic [DEPTH-1:0][ROW_W-1:0]  row_i,
   input  logic [DEPTH-1:0]             wr_i,
   input  logic [DEPTH-1:0]             valid_i,
   input  logic [BANKS-1:0]             open_i,
   input  logic [BANKS-1:0][ROW_W-1:0]  open_row_i,
   input  logic [BANKS-1:0]             col_ok_i,
   input  logic [BANKS-1:0]             act_ok_i,
   input  logic                         fifo_mode_i,
   output logic                         sel_valid_o,
   output logic [IDX_W-1:0]             sel_idx_o,
   output dram_cmd_e                    sel_cmd_o
);
   logic [DEPTH-1:0] hit, legal, older, cand_hit, cand_miss;
   logic [BANKS-1:0] bank_hit;
   dram_cmd_e        need [DEPTH];

   always_comb begin
      bank_hit = '0;
      for (int i = 0; i < DEPTH; i++) begin
         hit[i] = valid_i[i] && open_i[bank_i[i]] && (open_row_i[bank_i[i]] == row_i[i]);
         if (!open_i[bank_i[i]]) begin
            need[i]  = CMD_ACT;
            legal[i] = valid_i[i] && act_ok_i[bank_i[i]];
         end else if (hit[i]) begin
            need[i]  = wr_i[i] ? CMD_WR : CMD_RD;
            legal[i] = valid_i[i] && col_ok_i[bank_i[i]];
         end else begin
            need[i]  = CMD_PRE;
            legal[i] = valid_i[i];
         end
         if (hit[i]) bank_hit[bank_i[i]] = 1'b1;
         older[i] = 1'b0;
         for (int j = 0; j < i; j++)
            if (valid_i[j] && bank_i[j] == bank_i[i]) older[i] = 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
         cand_hit[i]  = hit[i] && legal[i];
         cand_miss[i] = legal[i] && !hit[i] && !older[i] && !bank_hit[bank_i[i]];
      end
      sel_valid_o = 1'b0;
      sel_idx_o   = '0;
      if (fifo_mode_i) begin
         sel_valid_o = legal[0];
      end else if (|cand_hit) begin
         sel_valid_o = 1'b1;
         for (int i = DEPTH - 1; i >= 0; i--)
            if (cand_hit[i]) sel_idx_o = IDX_W'(i);
      end else if (|cand_miss) begin
         sel_valid_o = 1'b1;
         for (int i = DEPTH - 1; i >= 0; i--)
            if (cand_miss[i]) sel_idx_o = IDX_W'(i);
      end
      sel_cmd_o = need[sel_idx_o];
   end
endmodule

// File: rtl/dram_frfcfs_sched.sv
module dram_frfcfs_sched import dram_sched_pkg::*; #(
   parameter int BANKS  = 4,
   parameter int ROW_W  = 8,
   parameter int COL_W  = 6,
   parameter int TAG_W  = 4,
   parameter int QDEPTH = 4,
   parameter int TRCD   = 3,
   parameter int TRP    = 2,
   parameter int TRC    = 7,
   localparam int BANK_W = $clog2(BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic              req_valid,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_write,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic [2:0]        cmd_kind,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic              done_valid,
   output logic [TAG_W-1:0]  done_tag
);
   localparam int IDX_W   = $clog2(QDEPTH);
   localparam int ROW_LO  = COL_W;
   localparam int BANK_LO = ROW_LO + ROW_W;
   localparam int WR_BIT  = BANK_LO + BANK_W;
   localparam int TAG_LO  = WR_BIT + 1;
   localparam int ENT_W   = TAG_LO + TAG_W;

   if (BANKS < 2 || (1 << BANK_W) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (QDEPTH < 2) begin : g_bad_depth
      $error("QDEPTH must be at least 2");
   end
   if (TRCD < 1 || TRP < 1 || TRC < 1) begin : g_bad_timing
      $error("TRCD, TRP and TRC must be at least 1");
   end

   logic [QDEPTH-1:0][ENT_W-1:0]  ent;
   logic [QDEPTH-1:0]             ent_valid, ent_wr;
   logic [QDEPTH-1:0][BANK_W-1:0] ent_bank;
   logic [QDEPTH-1:0][ROW_W-1:0]  ent_row;
   logic                          q_full, push, pop, sel_valid;
   logic [IDX_W-1:0]              sel_idx;
   dram_cmd_e                     sel_cmd;
   logic [ENT_W-1:0]              sel_ent;
   logic [BANK_W-1:0]             sel_bank;
   logic [BANKS-1:0]              b_open, b_col_ok, b_act_ok;
   logic [BANKS-1:0][ROW_W-1:0]   b_row;

   assign push = req_valid && !q_full;
   assign pop  = sel_valid && (sel_cmd == CMD_RD || sel_cmd == CMD_WR);

   dram_req_queue #(.DEPTH(QDEPTH), .ENT_W(ENT_W)) u_queue (
      .clk, .rst_n,
      .push_i      (push),
      .push_data_i ({req_tag, req_write, req_bank, req_row, req_col}),
      .pop_i       (pop),
      .pop_idx_i   (sel_idx),
      .ent_o       (ent),
      .valid_o     (ent_valid),
      .full_o      (q_full)
   );

   for (genvar g = 0; g < QDEPTH; g++) begin : g_fields
      assign ent_bank[g] = ent[g][BANK_LO +: BANK_W];
      assign ent_row[g]  = ent[g][ROW_LO +: ROW_W];
      assign ent_wr[g]   = ent[g][WR_BIT];
   end

   dram_req_pick #(.DEPTH(QDEPTH), .BANKS(BANKS), .ROW_W(ROW_W)) u_pick (
      .bank_i      (ent_bank),
      .row_i       (ent_row),
      .wr_i        (ent_wr),
      .valid_i     (ent_valid),
      .open_i      (b_open),
      .open_row_i  (b_row),
      .col_ok_i    (b_col_ok),
      .act_ok_i    (b_act_ok),
      .fifo_mode_i (fifo_mode),
      .sel_valid_o (sel_valid),
      .sel_idx_o   (sel_idx),
      .sel_cmd_o   (sel_cmd)
   );

   assign sel_ent  = ent[sel_idx];
   assign sel_bank = sel_ent[BANK_LO +: BANK_W];

   for (genvar g = 0; g < BANKS; g++) begin : g_bank
      logic mine;
      assign mine = sel_valid && (sel_bank == BANK_W'(g));
      dram_bank_timer #(.ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .TRC(TRC)) u_timer (
         .clk, .rst_n,
         .act_i    (mine && sel_cmd == CMD_ACT),
         .pre_i    (mine && sel_cmd == CMD_PRE),
         .row_i    (sel_ent[ROW_LO +: ROW_W]),
         .open_o   (b_open[g]),
         .row_o    (b_row[g]),
         .col_ok_o (b_col_ok[g]),
         .act_ok_o (b_act_ok[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid  <= 1'b0;
         cmd_kind   <= CMD_NONE;
         cmd_bank   <= '0;
         cmd_row    <= '0;
         cmd_col    <= '0;
         done_valid <= 1'b0;
         done_tag   <= '0;
      end else begin
         cmd_valid  <= sel_valid;
         cmd_kind   <= sel_valid ? sel_cmd : CMD_NONE;
         cmd_bank   <= sel_valid ? sel_bank : '0;
         cmd_row    <= (sel_valid && sel_cmd != CMD_PRE) ? sel_ent[ROW_LO +: ROW_W] : '0;
         cmd_col    <= pop ? sel_ent[COL_W-1:0] : '0;
         done_valid <= pop;
         done_tag   <= pop ? sel_ent[TAG_LO +: TAG_W] : '0;
      end
   end

   assign req_ready = !q_full;
endmodule

// File: rtl/dram_sched_checker.sv
module dram_sched_checker #(
   parameter int BANKS  = 4,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 8,
   parameter int TRCD   = 3,
   parameter int TRP    = 2,
   parameter int TRC    = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_kind,
   input logic [BANK_W-1:0] cmd_bank,
   input logic [ROW_W-1:0]  cmd_row,
   input logic              done_valid
);
   localparam int SAT = 1 << 20;
   int               since_act [BANKS];
   int               since_pre [BANKS];
   logic [BANKS-1:0] open_t;
   logic [ROW_W-1:0] row_t [BANKS];
   logic             is_col;

   assign is_col = cmd_valid && (cmd_kind == 3'd3 || cmd_kind == 3'd4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < BANKS; b++) begin
            since_act[b] <= SAT;
            since_pre[b] <= SAT;
            row_t[b]     <= '0;
         end
         open_t <= '0;
      end else begin
         for (int b = 0; b < BANKS; b++) begin
            if (cmd_valid && cmd_kind == 3'd1 && cmd_bank == BANK_W'(b)) begin
               since_act[b] <= 1;
               open_t[b]    <= 1'b1;
               row_t[b]     <= cmd_row;
            end else if (since_act[b] < SAT) begin
               since_act[b] <= since_act[b] + 1;
            end
            if (cmd_valid && cmd_kind == 3'd2 && cmd_bank == BANK_W'(b)) begin
               since_pre[b] <= 1;
               open_t[b]    <= 1'b0;
            end else if (since_pre[b] < SAT) begin
               since_pre[b] <= since_pre[b] + 1;
            end
         end
      end
   end

   assert_act_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 3'd1) |-> !open_t[cmd_bank]);
   assert_pre_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 3'd2) |-> open_t[cmd_bank]);
   assert_col_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (open_t[cmd_bank] && row_t[cmd_bank] == cmd_row));
   assert_done_with_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid == is_col);
   assert_idle_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> cmd_kind == 3'd0);

   for (genvar g = 0; g < BANKS; g++) begin : g_chk
      assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (is_col && cmd_bank == BANK_W'(g)) |-> since_act[g] >= TRCD);
      assert_rp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && cmd_kind == 3'd1 && cmd_bank == BANK_W'(g)) |-> since_pre[g] >= TRP);
      assert_rc_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && cmd_kind == 3'd1 && cmd_bank == BANK_W'(g)) |-> since_act[g] >= TRC);
   end
endmodule

bind dram_frfcfs_sched dram_sched_checker #(
   .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
   .TRCD(TRCD), .TRP(TRP), .TRC(TRC)
) u_sched_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
   .cmd_bank(cmd_bank), .cmd_row(cmd_row), .done_valid(done_valid)
);

// File: tb/dram_frfcfs_sched_test.sv
module dram_frfcfs_sched_test;
   localparam int NB = 4, BW = 2, RW = 8, CLW = 6, TW = 4, QD = 4;
   localparam int T_RCD = 3, T_RP = 2, T_RC = 7;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           rst_n, fifo_mode, req_valid, req_write, req_ready;
   logic [BW-1:0]  req_bank, cmd_bank;
   logic [RW-1:0]  req_row, cmd_row;
   logic [CLW-1:0] req_col, cmd_col;
   logic [TW-1:0]  req_tag, done_tag;
   logic           cmd_valid, done_valid;
   logic [2:0]     cmd_kind;

   dram_frfcfs_sched #(.BANKS(NB), .ROW_W(RW), .COL_W(CLW), .TAG_W(TW), .QDEPTH(QD),
                       .TRCD(T_RCD), .TRP(T_RP), .TRC(T_RC)) uut (
      .clk, .rst_n, .fifo_mode, .req_valid, .req_bank, .req_row, .req_col,
      .req_write, .req_tag, .req_ready, .cmd_valid, .cmd_kind, .cmd_bank,
      .cmd_row, .cmd_col, .done_valid, .done_tag);

   // Behavioural reference: an age-ordered list plus per-bank earliest-legal cycles.
   typedef struct {int bank; int row; int col; int wr; int tag;} mreq_t;
   mreq_t mq[$];
   int m_open[NB], m_row[NB], m_col_at[NB], m_act_at[NB];
   int cyc = 0;
   int e_valid, e_kind, e_bank, e_row, e_col, e_done, e_tag, e_ready;
   int n_cmp = 0, n_bad = 0, tag_n = 0;
   string cur_req = "R1";
   bit armed = 0;

   function automatic int need_of(int i);
      mreq_t r = mq[i];
      if (m_open[r.bank] == 0) return 1;
      if (m_row[r.bank] == r.row) return r.wr ? 4 : 3;
      return 2;
   endfunction

   function automatic bit ok_of(int i);
      int k = need_of(i);
      if (k == 1) return cyc >= m_act_at[mq[i].bank];
      if (k == 2) return 1;
      return cyc >= m_col_at[mq[i].bank];
   endfunction

   function automatic void model_pick(output int idx, output int kind);
      bit bh[NB];
      idx = -1; kind = 0;
      foreach (bh[b]) bh[b] = 0;
      foreach (mq[i]) if (need_of(i) >= 3) bh[mq[i].bank] = 1;
      if (fifo_mode) begin
         if (mq.size() > 0 && ok_of(0)) idx = 0;
      end else begin
         foreach (mq[i]) if (idx < 0 && need_of(i) >= 3 && ok_of(i)) idx = i;
         if (idx < 0) begin
            foreach (mq[i]) begin
               bit older = 0;
               for (int j = 0; j < i; j++) if (mq[j].bank == mq[i].bank) older = 1;
               if (idx < 0 && need_of(i) < 3 && ok_of(i) && !older && !bh[mq[i].bank]) idx = i;
            end
         end
      end
      if (idx >= 0) kind = need_of(idx);
   endfunction

   always @(posedge clk) begin : model
      int idx, kind, sz;
      mreq_t r, n;
      e_valid = 0; e_kind = 0; e_bank = 0; e_row = 0; e_col = 0; e_done = 0; e_tag = 0;
      if (!rst_n) begin
         mq.delete();
         for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_row[b] = 0; m_col_at[b] = 0; m_act_at[b] = 0;
         end
      end else begin
         sz = mq.size();
         model_pick(idx, kind);
         if (idx >= 0) begin
            r = mq[idx];
            e_valid = 1; e_kind = kind; e_bank = r.bank;
            e_row = (kind == 2) ? 0 : r.row;
            if (kind == 1) begin
               m_open[r.bank] = 1; m_row[r.bank] = r.row;
               m_col_at[r.bank] = cyc + T_RCD; m_act_at[r.bank] = cyc + T_RC;
            end else if (kind == 2) begin
               m_open[r.bank] = 0;
               if (cyc + T_RP > m_act_at[r.bank]) m_act_at[r.bank] = cyc + T_RP;
            end else begin
               e_col = r.col; e_done = 1; e_tag = r.tag;
               mq.delete(idx);
            end
         end
         if (req_valid && sz < QD) begin
            n.bank = int'(req_bank); n.row = int'(req_row); n.col = int'(req_col);
            n.wr = int'(req_write); n.tag = int'(req_tag);
            mq.push_back(n);
         end
      end
      e_ready = (mq.size() < QD);
      cyc++;
      armed = 1;
   end

   // Every clock: the whole bus, completion and ready compared with the model.
   always @(negedge clk) begin
      if (armed) begin
         n_cmp++;
         if (int'(cmd_valid) != e_valid || int'(cmd_kind) != e_kind || int'(cmd_bank) != e_bank ||
             int'(cmd_row) != e_row || int'(cmd_col) != e_col || int'(done_valid) != e_done ||
             int'(done_tag) != e_tag || int'(req_ready) != e_ready) begin
            n_bad++;
            $display("FAIL %s cyc %0d: got v%0d k%0d b%0d r%0d c%0d d%0d t%0d rdy%0d, expected v%0d k%0d b%0d r%0d c%0d d%0d t%0d rdy%0d",
               cur_req, cyc, cmd_valid, cmd_kind, cmd_bank, cmd_row, cmd_col, done_valid, done_tag,
               req_ready, e_valid, e_kind, e_bank, e_row, e_col, e_done, e_tag, e_ready);
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cyc > 60000) begin
         n_bad++;
         $display("FAIL watchdog %s: run did not end, cycle %0d expected below 60000", cur_req, cyc);
         finish_run();
      end
   end

   task automatic drive(int b, int r, int c, int w);
      req_valid = 1; req_bank = BW'(b); req_row = RW'(r); req_col = CLW'(c);
      req_write = w[0]; req_tag = TW'(tag_n); tag_n++;
   endtask

   // Offer one request and hold it until it is taken.
   task automatic push(int b, int r, int c, int w);
      @(negedge clk);
      drive(b, r, c, w);
      while (!req_ready) @(negedge clk);
   endtask

   // Offer one request for exactly one cycle, taken or not.
   task automatic blast(int b, int r, int c, int w);
      @(negedge clk);
      drive(b, r, c, w);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain();
      int k = 0;
      idle();
      while (mq.size() != 0 && k < 3000) begin
         @(negedge clk);
         k++;
      end
      repeat (T_RC + 2) @(negedge clk);
   endtask

   initial begin
      rst_n = 0; fifo_mode = 1; req_valid = 0; req_bank = '0; req_row = '0;
      req_col = '0; req_write = 0; req_tag = '0;
      // R1: reset state held and observed.
      cur_req = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R7 with R3, R4, R5, R6: in-order service, row conflicts on bank 0.
      cur_req = "R7 R3 R4 R5 R6";
      push(0, 5, 1, 0);
      push(0, 9, 2, 1);
      push(0, 5, 3, 0);
      push(1, 2, 4, 0);
      drain();

      // R8 and R9: open-row hits jump ahead, misses wait behind hits.
      cur_req = "R8 R9";
      @(negedge clk);
      fifo_mode = 0;
      push(0, 7, 1, 0);
      push(2, 3, 0, 1);
      push(0, 5, 2, 0);
      push(1, 2, 5, 1);
      push(0, 5, 6, 0);
      push(1, 11, 7, 0);
      push(1, 2, 8, 0);
      drain();

      // R2: back-to-back offers overrun the queue; rejected ones are never served.
      cur_req = "R2";
      for (int i = 0; i < 8; i++) blast(3, 4, i, i % 2);
      drain();

      // R11: all banks in parallel, activates interleave.
      cur_req = "R11";
      for (int b = 0; b < NB; b++) push(b, 1, b, 0);
      for (int b = 0; b < NB; b++) push(b, 2, b + 8, 1);
      drain();

      // R9: older same-bank miss blocks a younger miss to that bank.
      cur_req = "R9";
      push(2, 20, 1, 0);
      push(2, 21, 2, 0);
      push(3, 22, 3, 0);
      drain();

      // R10: mixed stream, both policies, completion tags checked every cycle.
      cur_req = "R10";
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if (k % 150 == 0) fifo_mode = ~fifo_mode;
         if ($urandom_range(0, 1) == 1)
            drive($urandom_range(0, NB - 1), $urandom_range(0, 3), $urandom_range(0, 63),
                  $urandom_range(0, 1));
         else
            req_valid = 0;
      end
      drain();

      finish_run();
   end
endmodule